// File: doc/BRIEF.md
# Link Test Pattern Source

This block drives the parallel side of a serial link with a known data stream so that the far end can measure errors. One of four pseudo-random sequences, a fast toggling word or a slow square-wave word can be selected, or a bypass path can forward the design's own data unchanged. The mode is chosen on the start pulse and held until the next start.

Before the pattern begins, the block can send a fixed sync word for a set number of beats. This gives the receiver something to lock onto. A one-shot inject request inverts a single bit of the stream, which lets the receiver's error counter be tested. Stop returns the output to an idle, all-zero, not-valid state. A start pulse while the block is already running restarts the sequence from its seed.

Top module: `link_pattern_source`

## Requirements
- R1: While reset is asserted and after its release, `valid_o` is 0 and `data_o` is all zeros until a start is accepted. Whenever `valid_o` is 0, `data_o` is all zeros.
- R2: Mode codes 0, 1, 2 and 3 select the pseudo-random sequences with polynomials x^7+x^6+1, x^15+x^14+1, x^23+x^18+1 and x^31+x^28+1. On each accepted start the shift register is seeded with all ones. Each step computes feedback = s[N-1] xor s[T-1] and shifts left with the feedback entering bit 0. Each beat carries 32 feedback bits, the first in bit 31.
- R3: Mode 4 outputs 32'hAAAA_AAAA on every pattern beat.
- R4: Mode 5 outputs 32'hFFFF_0000 on every pattern beat.
- R5: Modes 6 and 7 forward `user_data_i` to `data_o` in the same cycle on every pattern beat.
- R6: With the preamble disabled, the first pattern beat is valid in the cycle right after the clock edge that accepts start.
- R7: With the preamble enabled and a nonzero count N, the sync word captured at start is output for N valid beats. The first pattern beat follows directly after them. Changes to `pre_word_i` after start have no effect.
- R8: A preamble count of zero behaves exactly like a disabled preamble.
- R9: A stop sampled at a clock edge makes the output idle from that edge. Stop takes priority over a start in the same cycle.
- R10: An inject pulse inverts bit 0 of the next valid beat only. Several pulses that arrive while the block is idle and an injection is pending produce one flip.
- R11: A start accepted while the block is running restarts the selected mode from its seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start or restart the stream, sampled on the edge |
| stop_i | input | 1 | Halt the stream; wins over start |
| mode_i | input | 3 | Pattern select, captured at start |
| pre_en_i | input | 1 | Send the sync word before the pattern |
| pre_word_i | input | 32 | Sync word, captured at start |
| pre_beats_i | input | 16 | Number of sync beats |
| inject_i | input | 1 | Request a single-bit error |
| user_data_i | input | 32 | Data forwarded in bypass modes |
| data_o | output | 32 | Output beat |
| valid_o | output | 1 | Output beat is valid |

## Verification
A shift register that is seeded or advanced wrongly corrupts the very first pattern beat after start. Because the words are compared bit-exactly, this shows up one cycle after the start edge. An off-by-one in the sync counter shifts every following beat by one position, so the first pattern beat already mismatches. A pending-inject flag that is stuck or dropped shows up as a missing flipped bit on the next valid beat, or as a flip on a later beat that expected none. Leakage of state into idle shows at once as nonzero data while valid is low.

// File: rtl/lps_pkg.sv
package lps_pkg;
  typedef enum logic [2:0] {
    PAT_PRBS7   = 3'd0,
    PAT_PRBS15  = 3'd1,
    PAT_PRBS23  = 3'd2,
    PAT_PRBS31  = 3'd3,
    PAT_HIFREQ  = 3'd4,
    PAT_LOFREQ  = 3'd5,
    PAT_BYPASS  = 3'd6,
    PAT_BYPASS2 = 3'd7
  } pat_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_RUN  = 2'd2
  } st_e;

  localparam int unsigned NUM_PRBS = 4;
endpackage

// File: rtl/lps_lfsr.sv
module lps_lfsr #(
  parameter int unsigned LEN   = 7,
  parameter int unsigned TAP   = 6,
  parameter int unsigned OUT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             seed_i,
  input  logic             step_i,
  output logic [OUT_W-1:0] word_o
);
  logic [LEN-1:0] st_q, st_nxt;

  // OUT_W serial steps per beat, first feedback bit lands in the MSB
  always_comb begin
    logic [LEN-1:0] s;
    logic           fb;
    s = st_q;
    word_o = '0;
    for (int i = 0; i < OUT_W; i++) begin
      fb = s[LEN-1] ^ s[TAP-1];
      s  = {s[LEN-2:0], fb};
      word_o[OUT_W-1-i] = fb;
    end
    st_nxt = s;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= '1;
    else if (seed_i) st_q <= '1;
    else if (step_i) st_q <= st_nxt;
  end

  p_lfsr_live_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q != '0);
  p_lfsr_seed_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_i |=> st_q == '1);
endmodule

// File: rtl/lps_ctrl.sv
module lps_ctrl
  import lps_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             pre_en_i,
  input  logic [CNT_W-1:0] pre_beats_i,
  output st_e              st_o,
  output logic             launch_o
);
  st_e              st_q;
  logic [CNT_W-1:0] cnt_q;

  assign launch_o = start_i & ~stop_i;
  assign st_o     = st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else if (stop_i) begin
      st_q <= ST_IDLE;
    end else if (start_i) begin
      if (pre_en_i && pre_beats_i != '0) begin
        st_q  <= ST_PRE;
        cnt_q <= pre_beats_i;
      end else begin
        st_q <= ST_RUN;
      end
    end else if (st_q == ST_PRE) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) st_q <= ST_RUN;
    end
  end

  p_stop_halts_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> st_q == ST_IDLE);
  p_direct_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i && (!pre_en_i || pre_beats_i == '0)) |=> st_q == ST_RUN);
  p_pre_count_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_PRE |-> cnt_q != '0);
  p_no_zero_pre_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && pre_beats_i == '0) |=> st_q != ST_PRE);
endmodule

// File: rtl/lps_inject.sv
module lps_inject (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inject_i,
  input  logic valid_i,
  output logic flip_o
);
  logic pend_q;

  assign flip_o = pend_q & valid_i;

  // pulses merge while pending; consumed by the first valid beat
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= inject_i | (pend_q & ~valid_i);
  end

  p_single_flip_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flip_o && !inject_i) |=> !pend_q);
  p_keep_pending_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !valid_i) |=> pend_q);
endmodule

// File: rtl/link_pattern_source.sv
module link_pattern_source
  import lps_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [2:0]        mode_i,
  input  logic              pre_en_i,
  input  logic [DATA_W-1:0] pre_word_i,
  input  logic [CNT_W-1:0]  pre_beats_i,
  input  logic              inject_i,
  input  logic [DATA_W-1:0] user_data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned LEN [NUM_PRBS] = '{7, 15, 23, 31};
  localparam int unsigned TAP [NUM_PRBS] = '{6, 14, 18, 28};
  localparam logic [DATA_W-1:0] HI_WORD = {HALF_W{2'b10}};
  localparam logic [DATA_W-1:0] LO_WORD = {{HALF_W{1'b1}}, {HALF_W{1'b0}}};

  st_e               st;
  logic              launch, flip;
  pat_e              mode_q;
  logic [DATA_W-1:0] pre_word_q, pat_word;
  logic [DATA_W-1:0] prbs_w [NUM_PRBS];

  lps_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .pre_en_i    (pre_en_i),
    .pre_beats_i (pre_beats_i),
    .st_o        (st),
    .launch_o    (launch)
  );

  for (genvar g = 0; g < NUM_PRBS; g++) begin : g_prbs
    lps_lfsr #(.LEN(LEN[g]), .TAP(TAP[g]), .OUT_W(DATA_W)) u_lfsr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .seed_i (launch),
      .step_i (st == ST_RUN),
      .word_o (prbs_w[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= PAT_PRBS7;
      pre_word_q <= '0;
    end else if (launch) begin
      mode_q     <= pat_e'(mode_i);
      pre_word_q <= pre_word_i;
    end
  end

  assign valid_o = (st != ST_IDLE);

  lps_inject u_inject (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inject_i (inject_i),
    .valid_i  (valid_o),
    .flip_o   (flip)
  );

  always_comb begin
    unique case (mode_q)
      PAT_PRBS7:  pat_word = prbs_w[0];
      PAT_PRBS15: pat_word = prbs_w[1];
      PAT_PRBS23: pat_word = prbs_w[2];
      PAT_PRBS31: pat_word = prbs_w[3];
      PAT_HIFREQ: pat_word = HI_WORD;
      PAT_LOFREQ: pat_word = LO_WORD;
      default:    pat_word = user_data_i;
    endcase
  end

  always_comb begin
    if (st == ST_IDLE)     data_o = '0;
    else if (st == ST_PRE) data_o = pre_word_q ^ DATA_W'(flip);
    else                   data_o = pat_word ^ DATA_W'(flip);
  end

  p_idle_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> data_o == '0);
  p_word_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_PRE && !launch) |=> $stable(pre_word_q));
endmodule

// File: tb/link_pattern_source_test.sv
`timescale 1ns/1ps
module link_pattern_source_test;
  import lps_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, stop = 1'b0, pre_en = 1'b0, inject = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [31:0] pre_word = '0, user_data = '0;
  logic [15:0] pre_beats = '0;
  logic [31:0] data;
  logic        valid;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  link_pattern_source uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .mode_i(mode), .pre_en_i(pre_en), .pre_word_i(pre_word),
    .pre_beats_i(pre_beats), .inject_i(inject), .user_data_i(user_data),
    .data_o(data), .valid_o(valid)
  );

  function automatic logic [31:0] prbs_next(input int n, input int t,
                                            inout logic [30:0] s);
    logic [31:0] w;
    logic        b;
    for (int i = 0; i < 32; i++) begin
      b = s[n-1] ^ s[t-1];
      s = {s[29:0], b};
      w[31-i] = b;
    end
    return w;
  endfunction

  // monitor: samples mid-low-phase, pops expected beats
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (valid) begin
        n_cmp++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R9 unexpected valid beat: actual %h expected idle", data);
        end else begin
          logic [31:0] e;
          string       tg;
          e  = exp_q.pop_front();
          tg = tag_q.pop_front();
          if (data !== e) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tg, data, e);
          end
        end
      end else begin
        n_cmp++;
        if (data !== 32'h0) begin
          n_bad++;
          $display("FAIL R1 R9 idle data: actual %h expected 00000000", data);
        end
      end
    end
  end

  // entered and left at a negedge
  task automatic go(input pat_e m, input bit pe, input logic [15:0] pb,
                    input logic [31:0] pw, input int nb, input int inj,
                    input bit inj_drive, input bit chain, input string tg);
    int          p, tot;
    logic [30:0] s;
    logic [31:0] e;
    int          ln, tp;
    p   = (pe && pb != 0) ? int'(pb) : 0;
    tot = p + nb;
    s   = '1;
    ln  = (m == PAT_PRBS7) ? 7 : (m == PAT_PRBS15) ? 15 : (m == PAT_PRBS23) ? 23 : 31;
    tp  = (m == PAT_PRBS7) ? 6 : (m == PAT_PRBS15) ? 14 : (m == PAT_PRBS23) ? 18 : 28;
    start = 1'b1; mode = m; pre_en = pe; pre_beats = pb; pre_word = pw;
    inject = inj_drive && (inj == 1);
    for (int k = 1; k <= tot; k++) begin
      @(negedge clk);
      start = 1'b0;
      pre_word = ~pw;
      inject = inj_drive && (k + 1 == inj);
      user_data = 32'hC0DE_0000 ^ (k * 32'h0101_0101);
      if (k <= p) e = pw;
      else begin
        case (m)
          PAT_HIFREQ: e = 32'hAAAA_AAAA;
          PAT_LOFREQ: e = 32'hFFFF_0000;
          PAT_BYPASS, PAT_BYPASS2: e = user_data;
          default: e = prbs_next(ln, tp, s);
        endcase
      end
      if (k == inj) e[0] = ~e[0];
      exp_q.push_back(e);
      tag_q.push_back($sformatf("%s beat %0d", tg, k));
    end
    inject = 1'b0;
    if (!chain) begin
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state observed by the monitor
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle_cycles(3);
    // R2 R6: each pseudo-random mode, no preamble
    go(PAT_PRBS7,  1'b0, 16'd0, 32'h0, 10, 0, 1'b0, 1'b0, "R2 R6 prbs7");
    go(PAT_PRBS15, 1'b0, 16'd0, 32'h0, 8,  0, 1'b0, 1'b0, "R2 prbs15");
    go(PAT_PRBS23, 1'b0, 16'd0, 32'h0, 8,  0, 1'b0, 1'b0, "R2 prbs23");
    go(PAT_PRBS31, 1'b0, 16'd0, 32'h0, 8,  0, 1'b0, 1'b0, "R2 prbs31");
    // R3 R4
    go(PAT_HIFREQ, 1'b0, 16'd0, 32'h0, 4, 0, 1'b0, 1'b0, "R3 hifreq");
    go(PAT_LOFREQ, 1'b0, 16'd0, 32'h0, 4, 0, 1'b0, 1'b0, "R4 lofreq");
    // R5: both bypass codes
    go(PAT_BYPASS,  1'b0, 16'd0, 32'h0, 6, 0, 1'b0, 1'b0, "R5 bypass6");
    go(PAT_BYPASS2, 1'b0, 16'd0, 32'h0, 3, 0, 1'b0, 1'b0, "R5 bypass7");
    // R7: preamble, word changed after start
    go(PAT_PRBS7,  1'b1, 16'd3, 32'h5A5A_C3C3, 5, 0, 1'b0, 1'b0, "R7 preamble prbs7");
    go(PAT_BYPASS, 1'b1, 16'd1, 32'h1234_5678, 3, 0, 1'b0, 1'b0, "R7 preamble bypass");
    // R8: zero count equals disabled
    go(PAT_PRBS15, 1'b1, 16'd0, 32'hDEAD_BEEF, 5, 0, 1'b0, 1'b0, "R8 zero count");
    // R10: inject mid-run, and inject during preamble
    go(PAT_PRBS31, 1'b0, 16'd0, 32'h0, 6, 3, 1'b1, 1'b0, "R10 inject beat3");
    go(PAT_LOFREQ, 1'b1, 16'd2, 32'h0F0F_0F0F, 3, 2, 1'b1, 1'b0, "R10 inject preamble");
    // R10: merged pulses while idle give one flip on the first beat
    repeat (3) begin
      inject = 1'b1; @(negedge clk);
      inject = 1'b0; @(negedge clk);
    end
    go(PAT_HIFREQ, 1'b0, 16'd0, 32'h0, 4, 1, 1'b0, 1'b0, "R10 merged pulses");
    // R11: restart while running reseeds
    go(PAT_PRBS7, 1'b0, 16'd0, 32'h0, 4, 0, 1'b0, 1'b1, "R11 first run");
    go(PAT_PRBS7, 1'b0, 16'd0, 32'h0, 4, 0, 1'b0, 1'b0, "R11 restarted run");
    // R9: start and stop together stay idle
    start = 1'b1; stop = 1'b1;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
    idle_cycles(4);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R6 missing beats: actual %0d left expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule